// File: doc/BRIEF.md
# Variable-Length Serial Data Path

This block is the data path of a synchronous serial controller. One byte-wide CPU data address serves as both the transmit holding register and the receive register. A CPU write fills the transmit holding register. A CPU read returns the last received character. A shift register sits between the holding register and the serial pins. Characters may be 1 to 8 bits long, and the most significant bit always travels first.

Clock generation and chip select sit outside this block. The clock logic supplies two single-cycle strobes per bit. A sample strobe captures the incoming serial bit. A later shift strobe advances the shift register and brings the next outgoing bit to the serial output.

In master mode, an accepted write starts a character as soon as the shift register is free. In slave mode, an accepted write only preloads the shift register. The character then runs when the external master's strobes arrive.

Top module: `sdr_datapath`

## Requirements
- R1: After reset, `tx_empty` is 1, `rd_data` is 0, `xfer_busy` is 0, `xfer_done` is 0 and `ser_out` is 0.
- R2: A write while `tx_empty` is 1 is accepted. `tx_empty` reads 0 in the cycle after that edge.
- R3: A write while `tx_empty` is 0 is dropped. The held character is not replaced, and the dropped byte is never transmitted.
- R4: In master mode with the shifter idle, the held character moves into the shift register one clock after the write edge. `xfer_busy` then reads 1 and `tx_empty` returns to 1. `xfer_busy` returns to 0 after the last bit.
- R5: `ser_out` carries the shift register's bit 7. Transmit characters are left justified: a character of length L sends `wr_data[7]` down to `wr_data[8-L]`, in that order.
- R6: `char_len` is 3 bits wide. Code 0 selects 8-bit characters, and codes 1 to 7 select that many bits. The length is held for the duration of a character.
- R7: On the shift strobe of a character's last bit, `rd_data` takes the received character, right justified with zeros above it. In the same edge, `xfer_done` goes high for exactly one cycle. `rd_data` does not change at any other time.
- R8: In slave mode, an accepted write loads the shift register without setting `xfer_busy`. `xfer_busy` rises on the first shift strobe. Strobes are always honoured in slave mode. With no preload, the shift register's present contents (the previous received character, for 8-bit characters) go out.
- R9: In master mode, sample and shift strobes have no effect while no character is in progress.
- R10: A character written while another is being shifted is held in the transmit register. It starts in the cycle after the current character completes.
- R11: The bit shifted in is the `ser_in` value latched at the most recent sample strobe, not the value present at the shift strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| char_len | input | 3 | Character length code (0 means 8) |
| wr_en | input | 1 | CPU write strobe for the data address |
| wr_data | input | 8 | CPU write data, left justified |
| rd_data | output | 8 | Receive register, right justified |
| tx_empty | output | 1 | Transmit holding register can accept a write |
| sample_stb | input | 1 | Latch the incoming serial bit |
| shift_stb | input | 1 | Advance the shift register by one bit |
| ser_in | input | 1 | Incoming serial bit |
| ser_out | output | 1 | Outgoing serial bit |
| xfer_busy | output | 1 | A character is in progress |
| xfer_done | output | 1 | One-cycle pulse when the receive register updates |

## Verification
The hardest state to reach from the ports is a full transmit register while a character is already shifting. Only in that state is a third write dropped, and only there does the held character start automatically. The stimulus reaches it in three steps. It writes one byte. It waits for `xfer_busy`. It then writes twice more before driving any strobe. The dropped byte is detected when the following character's serial output matches the second byte. The bench also inverts `ser_in` between every sample and shift strobe, so that any use of the live pin value corrupts the received data.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam int unsigned SDR_DATA_W = 8;

    typedef enum logic {
        MODE_SLAVE  = 1'b0,
        MODE_MASTER = 1'b1
    } sdr_mode_e;

endpackage

// File: rtl/sdr_txbuf.sv
module sdr_txbuf #(
    parameter int DATA_W = sdr_pkg::SDR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.empty = 1'b1;
        end
        // A write lands only in an empty holding register
        if (wr_en_i && st_q.empty) begin
            st_d.data  = wr_data_i;
            st_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, empty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign empty_o = st_q.empty;

    // R2: accepted write fills the holding register
    a_r2_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && st_q.empty |=> !st_q.empty);

    // R3: a full holding register keeps its byte until the shifter takes it
    a_r3_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.empty && !take_i |=> !st_q.empty && $stable(st_q.data));

endmodule

// File: rtl/sdr_shifter.sv
module sdr_shifter #(
    parameter int DATA_W = sdr_pkg::SDR_DATA_W,
    parameter int LEN_W  = $clog2(DATA_W),
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic [LEN_W-1:0]  char_len_i,
    input  logic              tx_full_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              take_o,
    input  logic              sample_stb_i,
    input  logic              shift_stb_i,
    input  logic              ser_in_i,
    output logic              ser_out_o,
    output logic              active_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  len_o,
    output logic              cap_o,
    output logic [DATA_W-1:0] cap_word_o
);
    import sdr_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic              samp;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        logic              active;
        logic              done;
    } sh_state_t;

    sh_state_t st_d, st_q;

    logic [CNT_W-1:0]  len_req;
    logic [CNT_W-1:0]  len_use;
    logic              run;
    logic              take;
    logic              last_bit;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep_mask;

    function automatic logic [DATA_W-1:0] low_ones(input logic [CNT_W-1:0] n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(n)) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

    always_comb begin
        len_req   = (char_len_i == '0) ? CNT_W'(DATA_W) : CNT_W'(char_len_i);
        len_use   = st_q.active ? st_q.len : len_req;
        run       = st_q.active || (sdr_mode_e'(master_i) == MODE_SLAVE);
        take      = tx_full_i && !st_q.active && !shift_stb_i;
        shifted   = {st_q.sr[DATA_W-2:0], st_q.samp};
        keep_mask = low_ones(len_use);
        last_bit  = (st_q.cnt + CNT_W'(1)) == len_use;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            st_d.len = len_req;
        end
        if (sample_stb_i && run) begin
            st_d.samp = ser_in_i;
        end
        if (take) begin
            st_d.sr     = tx_data_i;
            st_d.cnt    = '0;
            st_d.active = (sdr_mode_e'(master_i) == MODE_MASTER);
        end else if (shift_stb_i && run) begin
            st_d.sr = shifted;
            if (last_bit) begin
                st_d.cnt    = '0;
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.cnt    = st_q.cnt + CNT_W'(1);
                st_d.active = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sr: '0, samp: 1'b0, cnt: '0, len: CNT_W'(DATA_W),
                      active: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o     = take;
    assign ser_out_o  = st_q.sr[DATA_W-1];
    assign active_o   = st_q.active;
    assign done_o     = st_q.done;
    assign len_o      = st_q.len;
    assign cap_o      = st_d.done;
    assign cap_word_o = shifted & keep_mask;

    // R4: in master mode a take starts the character
    a_r4_master_start: assert property (@(posedge clk) disable iff (!rst_n)
        take && master_i |=> st_q.active);

    // R8: in slave mode a take only preloads
    a_r8_slave_preload: assert property (@(posedge clk) disable iff (!rst_n)
        take && !master_i |=> !st_q.active);

    // R9: idle master ignores strobes
    a_r9_idle_master: assert property (@(posedge clk) disable iff (!rst_n)
        master_i && !st_q.active && !take |=> $stable(st_q.sr) && !st_q.active);

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R6: length stays fixed while a character runs
    a_r6_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |=> $stable(st_q.len));

endmodule

// File: rtl/sdr_rxbuf.sv
module sdr_rxbuf #(
    parameter int DATA_W = sdr_pkg::SDR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            st_d.data = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;

    // R7: receive register changes only at character completion
    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(st_q.data));

endmodule

// File: rtl/sdr_datapath.sv
module sdr_datapath #(
    parameter int DATA_W = sdr_pkg::SDR_DATA_W,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    input  logic              sample_stb,
    input  logic              shift_stb,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              xfer_busy,
    output logic              xfer_done
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] tx_data;
    logic              take;
    logic              cap;
    logic [DATA_W-1:0] cap_word;
    logic [CNT_W-1:0]  cur_len;
    logic [DATA_W-1:0] upper_mask;

    sdr_txbuf #(.DATA_W(DATA_W)) i_txbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .take_i    (take),
        .data_o    (tx_data),
        .empty_o   (tx_empty)
    );

    sdr_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_shifter (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_i     (master_mode),
        .char_len_i   (char_len),
        .tx_full_i    (!tx_empty),
        .tx_data_i    (tx_data),
        .take_o       (take),
        .sample_stb_i (sample_stb),
        .shift_stb_i  (shift_stb),
        .ser_in_i     (ser_in),
        .ser_out_o    (ser_out),
        .active_o     (xfer_busy),
        .done_o       (xfer_done),
        .len_o        (cur_len),
        .cap_o        (cap),
        .cap_word_o   (cap_word)
    );

    sdr_rxbuf #(.DATA_W(DATA_W)) i_rxbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (cap),
        .word_i (cap_word),
        .data_o (rd_data)
    );

    always_comb begin
        upper_mask = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i >= int'(cur_len)) begin
                upper_mask[i] = 1'b1;
            end
        end
    end

    // R7: received character is right justified with zero fill
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (rd_data & upper_mask) == '0);

    // R4: a take refills the empty flag
    a_r4_empty_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> tx_empty);

endmodule

// File: tb/test_sdr_datapath.sv
module test_sdr_datapath;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_mode = 1'b1;
    logic [2:0] char_len = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tx_empty;
    logic       sample_stb = 1'b0;
    logic       shift_stb = 1'b0;
    logic       ser_in = 1'b0;
    logic       ser_out;
    logic       xfer_busy;
    logic       xfer_done;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdr_datapath i_sdr_datapath (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .char_len    (char_len),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .tx_empty    (tx_empty),
        .sample_stb  (sample_stb),
        .shift_stb   (shift_stb),
        .ser_in      (ser_in),
        .ser_out     (ser_out),
        .xfer_busy   (xfer_busy),
        .xfer_done   (xfer_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int len);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < len; i++) m[i] = 1'b1;
        return m;
    endfunction

    // Driver: one accepted-or-not write, returns at the negedge after the edge
    task automatic do_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Driver: clocks one character and pushes the expected receive value
    task automatic run_bits(input logic [7:0] tx, input bit chk_tx, input int len,
                            input logic [7:0] rxv);
        exp_q.push_back(rxv & mask_of(len));
        for (int i = 0; i < len; i++) begin
            if (chk_tx) check($sformatf("R5 ser_out bit %0d", i), 32'(ser_out), 32'(tx[7-i]));
            ser_in     = rxv[len-1-i];
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
            ser_in     = ~rxv[len-1-i];   // R11: live pin differs at the shift strobe
            shift_stb  = 1'b1;
            @(negedge clk);
            shift_stb  = 1'b0;
        end
    endtask

    // Monitor: compares every completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && xfer_done) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected xfer_done", 32'(1), 32'(0));
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check("R7 rd_data on done", 32'(rd_data), 32'(e));
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 tx_empty", 32'(tx_empty), 32'(1));
        check("R1 rd_data", 32'(rd_data), 32'(0));
        check("R1 xfer_busy", 32'(xfer_busy), 32'(0));
        check("R1 xfer_done", 32'(xfer_done), 32'(0));
        check("R1 ser_out", 32'(ser_out), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // Master, 8-bit (code 0, R6)
        master_mode = 1'b1;
        char_len    = 3'd0;
        do_write(8'hC3);
        check("R2 empty after write", 32'(tx_empty), 32'(0));
        check("R4 not yet busy", 32'(xfer_busy), 32'(0));
        @(negedge clk);
        check("R4 busy after load", 32'(xfer_busy), 32'(1));
        check("R4 empty after load", 32'(tx_empty), 32'(1));
        run_bits(8'hC3, 1'b1, 8, 8'h5A);
        check("R4 busy cleared", 32'(xfer_busy), 32'(0));

        // Master, 4-bit, left justified transmit (R5, R6)
        char_len = 3'd4;
        do_write(8'hB7);
        @(negedge clk);
        run_bits(8'hB7, 1'b1, 4, 8'h06);

        // Master, 1-bit
        char_len = 3'd1;
        do_write(8'h80);
        @(negedge clk);
        run_bits(8'h80, 1'b1, 1, 8'h01);

        // Master, 7-bit
        char_len = 3'd7;
        do_write(8'h3C);
        @(negedge clk);
        run_bits(8'h3C, 1'b1, 7, 8'h55);

        // Full holding register: R3 drop, R10 chaining
        char_len = 3'd0;
        do_write(8'h11);
        @(negedge clk);
        do_write(8'h96);
        check("R2 second write held", 32'(tx_empty), 32'(0));
        do_write(8'hFF);
        check("R3 still full after dropped write", 32'(tx_empty), 32'(0));
        run_bits(8'h11, 1'b1, 8, 8'hE1);
        @(negedge clk);
        check("R10 held character started", 32'(xfer_busy), 32'(1));
        run_bits(8'h96, 1'b1, 8, 8'h0F);   // R3: 0xFF never sent
        check("R3 nothing left to send", 32'(tx_empty), 32'(1));

        // R9: idle master ignores strobes
        ser_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
            shift_stb  = 1'b1;
            @(negedge clk);
            shift_stb  = 1'b0;
        end
        check("R9 idle busy", 32'(xfer_busy), 32'(0));
        check("R9 rd_data unchanged", 32'(rd_data), 32'(8'h0F));
        char_len = 3'd3;
        do_write(8'h69);
        @(negedge clk);
        run_bits(8'h69, 1'b1, 3, 8'h05);

        // Slave mode (R8)
        master_mode = 1'b0;
        char_len    = 3'd0;
        do_write(8'hD2);
        check("R8 slave write accepted", 32'(tx_empty), 32'(0));
        @(negedge clk);
        check("R8 slave preload empties", 32'(tx_empty), 32'(1));
        check("R8 slave not busy after preload", 32'(xfer_busy), 32'(0));
        repeat (3) @(negedge clk);
        check("R8 slave waits for strobes", 32'(xfer_busy), 32'(0));
        exp_q.push_back(8'hA5);
        ser_in     = 1'b1;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        ser_in     = 1'b0;
        shift_stb  = 1'b1;
        @(negedge clk);
        shift_stb  = 1'b0;
        check("R8 slave busy after first shift", 32'(xfer_busy), 32'(1));
        for (int i = 1; i < 8; i++) begin
            check($sformatf("R5 slave ser_out bit %0d", i), 32'(ser_out), 32'(8'hD2 >> (7 - i) & 1));
            ser_in     = 8'hA5 >> (7 - i) & 8'h01 ? 1'b1 : 1'b0;
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
            ser_in     = ~ser_in;
            shift_stb  = 1'b1;
            @(negedge clk);
            shift_stb  = 1'b0;
        end
        // No preload: previous received byte goes out (R8)
        run_bits(8'hA5, 1'b1, 8, 8'h3C);

        // Slave 2-bit with preload
        char_len = 3'd2;
        do_write(8'h40);
        @(negedge clk);
        run_bits(8'h40, 1'b1, 2, 8'h02);

        repeat (4) @(negedge clk);
        check("R7 all completions seen", 32'(exp_q.size()), 32'(0));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule